// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block is the page latch between a serial memory front end and a nonvolatile array. The front end hands it a starting word address and then a stream of data bytes. Each byte goes into one of sixteen slots picked by the low four bits of a running pointer. Only those low bits advance, so the pointer wraps inside the page and a seventeenth byte replaces the first. Each slot carries a valid flag, and only slots that received a byte are ever programmed.

When the front end sees the stop condition it raises a commit strobe. If at least one byte is held and write protect is low, the block starts a self-timed write cycle. It raises busy for a fixed number of clock cycles and uses the first sixteen of them to sweep the slots in ascending order, issuing one array write for each valid slot. Load, byte and commit strobes that arrive while busy is high are dropped. A commit with an empty buffer, or with write protect high, discards the buffer and starts no cycle.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and no array write occurs until a commit.
- R2: A load strobe latches the 11-bit word address. Each accepted byte is stored at the slot given by the pointer's low 4 bits, and those bits then increment. The upper 7 bits stay fixed, and every array write carries them as `arr_addr_o[10:4]`.
- R3: After more than 16 bytes the pointer wraps inside the page, and a later byte overwrites the slot filled earlier, in arrival order.
- R4: No array write happens while bytes are being collected. Programming starts only on a commit strobe.
- R5: An accepted commit raises `busy_o` in the cycle after the commit edge, and it stays high for exactly WR_CYCLES cycles.
- R6: During the cycle, each valid slot i is written once, with `arr_addr_o = {page, i}` and its last byte. Writes come in ascending slot order. The write for slot i is visible i+1 cycles after `busy_o` first reads high, and slots without a byte are not written.
- R7: If `wp_i` is high at the commit, nothing is written and `busy_o` stays low. The buffered bytes are discarded, so a later commit also programs nothing. No array write is issued while `wp_i` is high.
- R8: Load, byte and commit strobes that arrive while `busy_o` is high have no effect. They neither change the running cycle nor are stored.
- R9: A commit with no byte received since the last load or commit starts no write cycle.
- R10: A new load strobe discards any bytes collected but not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_addr_i | input | 1 | Latch `addr_i` as the start address and empty the buffer |
| addr_i | input | 11 | Starting word address |
| byte_valid_i | input | 1 | Store `byte_i` at the current pointer |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop-condition strobe that requests programming |
| wp_i | input | 1 | Write protect, active high |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 11 | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The bench drives inputs at falling edges and samples outputs at the next falling edge. A strobe raised at one falling edge is therefore taken at the rising edge between, and `busy_o` is checked one sample later. A monitor stamps each sample with a running cycle number. The bench expects the write for slot i exactly i+1 samples after the first busy sample, counts WR_CYCLES busy samples, and checks that each write's address and data match a byte-level model of the wrapping pointer. For dropped strobes, the bench waits out the cycle and then issues a second commit, which shows at the ports whether anything was stored.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // advance only the low bits of a pointer, keeping the rest
  function automatic logic [15:0] low_wrap_inc(input logic [15:0] v, input int bits);
    logic [15:0] mask;
    mask = (16'd1 << bits) - 16'd1;
    return (v & ~mask) | ((v + 16'd1) & mask);
  endfunction
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [(1<<IDX_W)-1:0] valid
);
  localparam int SLOTS = 1 << IDX_W;

  logic [DATA_W-1:0] mem [SLOTS];

  // plain write port plus registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        valid <= '0;
    else if (clr)   valid <= '0;
    else if (wr_en) valid[wr_idx] <= 1'b1;
  end

  // R2: a stored byte marks its slot
  p_slot_marked_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> valid[$past(wr_idx)]);
  // R10: a clear empties every slot
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid == '0));
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int IDX_W     = 4,
  parameter int WR_CYCLES = 20000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             scan,
  output logic [IDX_W-1:0] scan_idx,
  output logic             done
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int CYC   = (WR_CYCLES < SLOTS) ? SLOTS : WR_CYCLES;
  localparam int CNT_W = $clog2(CYC) + 1;

  logic [CNT_W-1:0] cnt;

  assign done     = busy && (cnt == CNT_W'(CYC - 1));
  assign scan     = busy && (cnt < CNT_W'(SLOTS));
  assign scan_idx = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: busy ends only after the full count
  p_full_length_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == CNT_W'(CYC - 1)));
  // R5: the count never runs past its end
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(CYC)));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int WR_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              wp_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  import pwb_pkg::*;

  localparam int SLOTS  = 1 << IDX_W;
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] ptr;
  logic [SLOTS-1:0]  valid;
  logic              busy, scan, done;
  logic [IDX_W-1:0]  scan_idx;
  logic              idle, commit_go, commit_drop, ld_acc, wr_acc, clr;

  // strobe priority when idle: commit, then load, then byte
  assign idle        = !busy;
  assign commit_go   = idle && commit_i && (|valid) && !wp_i;
  assign commit_drop = idle && commit_i && !commit_go;
  assign ld_acc      = idle && !commit_i && load_addr_i;
  assign wr_acc      = idle && !commit_i && !load_addr_i && byte_valid_i;
  assign clr         = commit_drop || ld_acc || done;

  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (ld_acc) ptr <= addr_i;
    else if (wr_acc) ptr <= ADDR_W'(low_wrap_inc(16'(ptr), IDX_W));
  end

  pwb_slot_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_acc),
    .wr_idx  (ptr[IDX_W-1:0]),
    .wr_data (byte_i),
    .clr     (clr),
    .rd_idx  (scan_idx),
    .rd_data (arr_data_o),
    .valid   (valid)
  );

  pwb_cycle_timer #(.IDX_W(IDX_W), .WR_CYCLES(WR_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (commit_go),
    .busy     (busy),
    .scan     (scan),
    .scan_idx (scan_idx),
    .done     (done)
  );

  assign busy_o = busy;

  // registered write request, aligned with the registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we_o   <= 1'b0;
      arr_addr_o <= '0;
    end else begin
      arr_we_o   <= scan && valid[scan_idx] && !wp_i;
      arr_addr_o <= {ptr[ADDR_W-1:IDX_W], scan_idx};
    end
  end

  // R7: protected array sees no write
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> !$past(wp_i));
  // R4: writes only inside a write cycle
  p_write_in_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);
  // R9: a cycle starts only with buffered bytes
  p_start_needs_data_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(|valid));
  // R2: the page bits hold while bytes stream in
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (ptr[ADDR_W-1:IDX_W] == $past(ptr[ADDR_W-1:IDX_W])));
  // R8: strobes during busy leave the pointer alone
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done) |=> $stable(ptr));
  // R6: the buffer is empty once the cycle ends
  p_empty_after_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (valid == '0));
endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
  localparam int WR  = 24;
  localparam int NV  = 4;
  // {start address[24:14], byte count[13:8], first data byte[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {11'h123, 6'd1,  8'h10},
    {11'h7FD, 6'd5,  8'h20},
    {11'h040, 6'd16, 8'h30},
    {11'h2A3, 6'd19, 8'h50}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic load_addr_i = 0, byte_valid_i = 0, commit_i = 0, wp_i = 0;
  logic [10:0] addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic        arr_we_o, busy_o;
  logic [10:0] arr_addr_o;
  logic [7:0]  arr_data_o;

  always #4 clk = ~clk;

  page_write_buffer #(.WR_CYCLES(WR)) u_page_write_buffer (
    .clk(clk), .rst(rst), .load_addr_i(load_addr_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .commit_i(commit_i),
    .wp_i(wp_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o), .busy_o(busy_o));

  int checks = 0, errors = 0;
  int cyc = 0, cap_n = 0, busy_n = 0, first_busy = -1, first_we = -1;
  logic [10:0] cap_a [64];
  logic [7:0]  cap_d [64];
  logic [6:0]  m_page;
  logic [3:0]  m_slot;
  logic        m_v [16];
  logic [7:0]  m_d [16];

  always @(negedge clk) begin
    cyc++;
    if (busy_o) begin
      busy_n++;
      if (first_busy < 0) first_busy = cyc;
    end
    if (arr_we_o) begin
      if (first_we < 0) first_we = cyc;
      if (cap_n < 64) begin cap_a[cap_n] = arr_addr_o; cap_d[cap_n] = arr_data_o; end
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_n = 0; busy_n = 0; first_busy = -1; first_we = -1;
  endtask

  task automatic do_load(input logic [10:0] a);
    @(negedge clk); load_addr_i = 1; addr_i = a;
    @(negedge clk); load_addr_i = 0;
    if (!busy_o) begin
      m_page = a[10:4]; m_slot = a[3:0];
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_valid_i = 1; byte_i = d;
    @(negedge clk); byte_valid_i = 0;
  endtask

  task automatic model_byte(input logic [7:0] d);
    m_v[m_slot] = 1; m_d[m_slot] = d; m_slot = m_slot + 4'd1;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit_i = 1;
    @(negedge clk); commit_i = 0;
  endtask

  task automatic check_writes(input string req);
    int k, fs;
    k = 0; fs = -1;
    for (int s = 0; s < 16; s++) if (m_v[s]) begin
      if (fs < 0) fs = s;
      if (k < cap_n) begin
        chk(cap_a[k] == {m_page, 4'(s)}, req, "write address", cap_a[k], {m_page, 4'(s)});
        chk(cap_d[k] == m_d[s], req, "write data", cap_d[k], m_d[s]);
      end
      k++;
    end
    chk(cap_n == k, req, "write count", cap_n, k);
    if (fs >= 0) chk(first_we - first_busy == fs + 1, "R6", "first write offset", first_we - first_busy, fs + 1);
    for (int s = 0; s < 16; s++) m_v[s] = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    chk(arr_we_o == 0, "R1", "write enable after reset", arr_we_o, 0);

    // table walk: R2, R3, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      logic [10:0] a;
      int n;
      logic [7:0] sd;
      a = VEC[v][24:14]; n = int'(VEC[v][13:8]); sd = VEC[v][7:0];
      clear_cap();
      do_load(a);
      for (int j = 0; j < n; j++) begin
        do_byte(sd + 8'(j));
        model_byte(sd + 8'(j));
      end
      chk(cap_n == 0 && busy_o == 0, "R4", "no write before commit", cap_n, 0);
      @(negedge clk); commit_i = 1;
      @(negedge clk); commit_i = 0;
      chk(busy_o == 1, "R5", "busy one cycle after commit", busy_o, 1);
      repeat (WR + 4) @(negedge clk);
      chk(busy_n == WR, "R5", "busy length", busy_n, WR);
      check_writes(n > 16 ? "R3" : "R2");
    end

    // R7: protected commit discards the buffer
    clear_cap();
    do_load(11'h345); do_byte(8'hA1); do_byte(8'hA2);
    wp_i = 1;
    pulse_commit();
    repeat (WR + 2) @(negedge clk);
    chk(busy_n == 0, "R7", "busy under protect", busy_n, 0);
    chk(cap_n == 0, "R7", "writes under protect", cap_n, 0);
    wp_i = 0;
    pulse_commit();
    repeat (4) @(negedge clk);
    chk(busy_n == 0 && cap_n == 0, "R7", "discarded bytes not programmed", cap_n, 0);

    // R9: empty commit
    clear_cap();
    do_load(11'h111);
    pulse_commit();
    repeat (4) @(negedge clk);
    chk(busy_n == 0, "R9", "empty commit busy", busy_n, 0);

    // R10: reload drops uncommitted bytes
    clear_cap();
    do_load(11'h400); do_byte(8'hC1); do_byte(8'hC2);
    do_load(11'h60E); do_byte(8'hD1); model_byte(8'hD1);
    do_byte(8'hD2); model_byte(8'hD2); do_byte(8'hD3); model_byte(8'hD3);
    pulse_commit();
    repeat (WR + 4) @(negedge clk);
    check_writes("R10");

    // R8: strobes during busy are dropped
    clear_cap();
    do_load(11'h3C0); do_byte(8'hE0); model_byte(8'hE0);
    do_byte(8'hE1); model_byte(8'hE1);
    pulse_commit();
    do_load(11'h100); do_byte(8'hEE); pulse_commit();
    repeat (WR + 4) @(negedge clk);
    chk(busy_n == WR, "R8", "busy length with strobes", busy_n, WR);
    check_writes("R8");
    clear_cap();
    pulse_commit();
    repeat (4) @(negedge clk);
    chk(busy_n == 0 && cap_n == 0, "R8", "byte during busy not stored", cap_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule